// File: doc/BRIEF.md
# Dual-Mode Vector Byte Permute Unit

This block rearranges the bytes of a 128-bit vector. Every operand is treated as 16 byte lanes. For each output lane, the byte in the same lane of an index vector chooses one source byte. There are two ways to pick a byte. In the two-source mode, sources A and B form a 32-entry table. In the one-source mode, the table is source A alone, and an index byte with its top bit set clears its lane to zero.

The first mode suits fixed shuffles of a vector. Giving the same vector as both sources turns it into 16 parallel lookups in a 16-entry table. The second mode gives 16 small-table lookups where a flag bit can mark a lane as empty.

The unit has two register stages. Operands enter and results leave through valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high. `in_ready` is combinational from `out_ready` and the stage occupancy. A producer must hold its operands steady while `in_valid` is high and `in_ready` is low. While `out_valid` is high and `out_ready` is low, the result is held unchanged. When the consumer keeps `out_ready` high, one operation is accepted every cycle and none is lost or repeated.

Top module: `byte_permute_unit`

## Requirements
- R1: With `in_mode` = 0 (two-source), output lane i is entry `in_index[8i+4:8i]` of a 32-byte table. Entries 0..15 are bytes 0..15 of `in_src_a` and entries 16..31 are bytes 0..15 of `in_src_b`. Byte lane k occupies bits [8k+7:8k]. Index bits 7, 6 and 5 are ignored, so a set bit 7 does not clear the lane.
- R2: With `in_mode` = 1 (one-source), output lane i is byte `in_index[8i+3:8i]` of `in_src_a` when index bit 7 of that lane is clear. Index bits 6..4 and all of `in_src_b` have no effect.
- R3: With `in_mode` = 1, a lane whose index byte has bit 7 set outputs 0x00, whatever its low index bits are.
- R4: With `in_mode` = 0 and `in_src_b` equal to `in_src_a`, output lane i is byte `in_index[8i+3:8i]` of `in_src_a` for any value of the upper index bits.
- R5: While `out_ready` is high, `in_ready` is high. An operation whose `in_valid` is high in cycle N has its result on `out_data`, with `out_valid` high, in cycle N+2.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value in the next cycle. `in_ready` is low only when both stages are full and `out_ready` is low.
- R7: A synchronous active-high `rst` empties both stages: after a reset cycle `out_valid` is low and `in_ready` is high. Data registers are not cleared.
- R8: Results leave in the order they were accepted, one per accepted operation. `out_valid` is never high without an accepted operation still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the stage valid bits |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_mode | input | 1 | 0 = two-source 32-entry select, 1 = one-source select with zeroing |
| in_src_a | input | 128 | Source A, table entries 0..15 |
| in_src_b | input | 128 | Source B, table entries 16..31 (two-source mode only) |
| in_index | input | 128 | One selector byte per output lane |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Permuted vector |

## Verification
The bench first applies fixed tables whose source bytes equal their own table position, so each output byte directly shows which entry was picked. These cases cover the identity, the reversal and the B-half selections. They also use uniform index bytes with bits 7, 6, 5 or 4 set. Those bytes separate "ignored" from "zeroing" in each mode and expose a swapped A/B half or a wrong mask width. Lanes with alternating zeroing and pass-through indices show that lanes do not influence each other. Random operands in both modes, with A equal to B in some of them, are then streamed under random back-pressure. They are compared in order against a reference model, which catches reordering, dropped or duplicated results and data that changes during a stall.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic {
    SEL_PAIR   = 1'b0,
    SEL_SINGLE = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/bpu_bank_sel.sv
module bpu_bank_sel #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] src,
  input  logic [LANES*LANE_W-1:0] idx,
  output logic [LANES*LANE_W-1:0] pick
);
  localparam int SEL_W = $clog2(LANES);

  logic [LANE_W-1:0] bank [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    assign bank[k] = src[k*LANE_W +: LANE_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel = idx[i*LANE_W +: SEL_W];
    assign pick[i*LANE_W +: LANE_W] = bank[sel];
  end
endmodule

// File: rtl/bpu_lane_merge.sv
module bpu_lane_merge #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] lo_pick,
  input  logic [LANES*LANE_W-1:0] hi_pick,
  input  logic [LANES-1:0]        take_hi,
  input  logic [LANES-1:0]        blank,
  output logic [LANES*LANE_W-1:0] merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (blank[i])
        merged[i*LANE_W +: LANE_W] = '0;
      else if (take_hi[i])
        merged[i*LANE_W +: LANE_W] = hi_pick[i*LANE_W +: LANE_W];
      else
        merged[i*LANE_W +: LANE_W] = lo_pick[i*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/bpu_pipe_ctrl.sv
module bpu_pipe_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic ld_s1,
  output logic ld_s2,
  output logic out_valid
);
  logic v1, v2;
  logic s1_open, s2_open;

  assign s2_open   = !v2 || out_ready;
  assign s1_open   = !v1 || s2_open;
  assign in_ready  = s1_open;
  assign ld_s1     = s1_open && in_valid;
  assign ld_s2     = s2_open && v1;
  assign out_valid = v2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      if (s1_open) v1 <= in_valid;
      if (s2_open) v2 <= v1;
    end
  end
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
  import bpu_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_mode,
  input  logic [LANES*LANE_W-1:0] in_src_a,
  input  logic [LANES*LANE_W-1:0] in_src_b,
  input  logic [LANES*LANE_W-1:0] in_index,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam int VEC_W    = LANES * LANE_W;
  localparam int SEL_W    = $clog2(LANES);
  localparam int HALF_BIT = SEL_W;
  localparam int ZERO_BIT = LANE_W - 1;

  sel_mode_e mode;
  assign mode = sel_mode_e'(in_mode);

  logic ld_s1, ld_s2;

  bpu_pipe_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .ld_s1     (ld_s1),
    .ld_s2     (ld_s2),
    .out_valid (out_valid)
  );

  // Stage 1: 16-way pick inside each half, plus per-lane steering flags
  logic [VEC_W-1:0] pick_a, pick_b;
  logic [LANES-1:0] want_hi, want_blank;

  bpu_bank_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_sel_a (
    .src (in_src_a), .idx (in_index), .pick (pick_a)
  );

  bpu_bank_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_sel_b (
    .src (in_src_b), .idx (in_index), .pick (pick_b)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_flag
    assign want_hi[i]    = (mode == SEL_PAIR)   && in_index[i*LANE_W + HALF_BIT];
    assign want_blank[i] = (mode == SEL_SINGLE) && in_index[i*LANE_W + ZERO_BIT];
  end

  logic [VEC_W-1:0] s1_lo, s1_hi;
  logic [LANES-1:0] s1_take_hi, s1_blank;

  always_ff @(posedge clk) begin
    if (ld_s1) begin
      s1_lo      <= pick_a;
      s1_hi      <= pick_b;
      s1_take_hi <= want_hi;
      s1_blank   <= want_blank;
    end
  end

  // Stage 2: choose the half or clear the lane
  logic [VEC_W-1:0] merged;

  bpu_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .lo_pick (s1_lo),
    .hi_pick (s1_hi),
    .take_hi (s1_take_hi),
    .blank   (s1_blank),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (ld_s2) out_data <= merged;
  end
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*LANE_W-1:0] out_data
);
  logic [2:0] inflight;
  logic       acc, del;

  assign acc = in_valid && in_ready;
  assign del = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + {2'b0, acc} - {2'b0, del};
  end

  // R7
  reset_empty_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

  // R5
  full_rate_chk: assert property (@(posedge clk) disable iff (rst) out_ready |-> in_ready);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  block_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));

  // R8
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != 3'd0));

  // R8
  depth_cap_chk: assert property (@(posedge clk) disable iff (rst) inflight <= 3'd2);
endmodule

bind byte_permute_unit bpu_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_bpu_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_byte_permute_unit.sv
`timescale 1ns/1ps
module tb_byte_permute_unit;
  localparam logic [127:0] TA = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [127:0] TB = 128'h1f1e1d1c1b1a19181716151413121110;

  typedef struct packed {
    logic         single;
    logic [127:0] idx;
    logic [127:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b0, TA, TA},
    '{1'b0, TB, TB},
    '{1'b0, {16{8'hE5}}, {16{8'h05}}},
    '{1'b0, {16{8'h93}}, {16{8'h13}}},
    '{1'b0, 128'h000102030405060708090a0b0c0d0e0f, 128'h000102030405060708090a0b0c0d0e0f},
    '{1'b1, {16{8'h7A}}, {16{8'h0A}}},
    '{1'b1, {16{8'h80}}, 128'h0},
    '{1'b1, {8{16'h8F01}}, {8{16'h0001}}},
    '{1'b1, TB, TA}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_mode = 1'b0;
  logic [127:0] in_src_a = '0;
  logic [127:0] in_src_b = '0;
  logic [127:0] in_index = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  byte_permute_unit dut (
    .clk (clk), .rst (rst),
    .in_valid (in_valid), .in_ready (in_ready), .in_mode (in_mode),
    .in_src_a (in_src_a), .in_src_b (in_src_b), .in_index (in_index),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data)
  );

  function automatic logic [127:0] ref_perm(input logic single, input logic [127:0] a,
                                            input logic [127:0] b, input logic [127:0] idx);
    logic [255:0] t;
    logic [127:0] r;
    t = {b, a};
    for (int i = 0; i < 16; i++) begin
      logic [7:0] c;
      c = idx[i*8 +: 8];
      if (single) r[i*8 +: 8] = c[7] ? 8'h00 : a[int'(c[3:0])*8 +: 8];
      else        r[i*8 +: 8] = t[int'(c[4:0])*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic single, input logic [127:0] a, input logic [127:0] b,
                        input logic [127:0] idx, input logic [127:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_mode = single; in_src_a = a; in_src_b = b; in_index = idx;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b1, {req, " R5 out_valid at N+2"}, {127'b0, out_valid}, 128'h1);
    check(out_data === exp, req, out_data, exp);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 no extra result", {127'b0, out_valid}, 128'h0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] q_exp [$];
    logic [127:0] held;
    logic         hold_pend;
    logic         acc_last;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(out_valid === 1'b0, "R7 out_valid after reset", {127'b0, out_valid}, 128'h0);
    check(in_ready === 1'b1, "R7 in_ready after reset", {127'b0, in_ready}, 128'h1);

    // Table walk: R1 (wide), R2/R3 (narrow)
    for (int n = 0; n < NV; n++) begin
      run_op(TBL[n].single, TA, TB, TBL[n].idx, TBL[n].exp,
             TBL[n].single ? "R2/R3 table" : "R1 table");
    end

    // R2: B has no effect in narrow mode
    run_op(1'b1, TA, ~TB, TA, TA, "R2 src_b ignored");
    // R3: zero lane with all low bits set
    run_op(1'b1, TA, TB, {16{8'hFF}}, 128'h0, "R3 zero with low bits set");

    // R4: same source in wide mode acts as 16-entry lookup
    for (int n = 0; n < 6; n++) begin
      logic [127:0] a, idx, e;
      a   = {$urandom, $urandom, $urandom, $urandom};
      idx = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < 16; i++) e[i*8 +: 8] = a[int'(idx[i*8 +: 4])*8 +: 8];
      run_op(1'b0, a, a, idx, e, "R4 shared source");
    end

    // R6: stall holds data and blocks input only when full
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_mode = 1'b0; in_src_a = TA; in_src_b = TB; in_index = TB;
    @(negedge clk);
    in_index = TA;
    #1;
    check(in_ready === 1'b1, "R6 ready with one stage free", {127'b0, in_ready}, 128'h1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(in_ready === 1'b0, "R6 not ready when full and stalled", {127'b0, in_ready}, 128'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && out_data === TB, "R6 held during stall", out_data, TB);
    end
    out_ready = 1'b1;
    #1;
    check(in_ready === 1'b1, "R5 ready follows out_ready", {127'b0, in_ready}, 128'h1);
    @(negedge clk);
    check(out_valid === 1'b1 && out_data === TA, "R8 second result in order", out_data, TA);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drained", {127'b0, out_valid}, 128'h0);

    // R7: reset mid-flight empties the pipeline
    in_valid = 1'b1; in_index = TA;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(out_valid === 1'b0, "R7 flushed by reset", {127'b0, out_valid}, 128'h0);
      check(in_ready === 1'b1, "R7 ready after flush", {127'b0, in_ready}, 128'h1);
      @(negedge clk);
    end

    // Streaming with random back-pressure: R1 R2 R3 R5 R6 R8
    hold_pend = 1'b0;
    acc_last  = 1'b0;
    held      = '0;
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk);
      if (hold_pend)
        check(out_valid === 1'b1 && out_data === held, "R6 stream hold", out_data, held);
      out_ready = ($urandom % 4) != 0;
      if (!in_valid || acc_last) begin
        in_valid = ($urandom % 3) != 0;
        in_mode  = $urandom % 2;
        in_src_a = {$urandom, $urandom, $urandom, $urandom};
        in_src_b = ($urandom % 4 == 0) ? in_src_a : {$urandom, $urandom, $urandom, $urandom};
        in_index = {$urandom, $urandom, $urandom, $urandom};
      end
      #1;
      acc_last = in_valid && in_ready;
      if (acc_last) q_exp.push_back(ref_perm(in_mode, in_src_a, in_src_b, in_index));
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R8 result without operation", out_data, 128'h0);
        end else begin
          logic [127:0] e;
          e = q_exp.pop_front();
          check(out_data === e, in_mode ? "R1/R2/R3 stream" : "R1/R4 stream", out_data, e);
        end
      end
      hold_pend = out_valid && !out_ready;
      held      = out_data;
    end

    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      if (out_valid) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R8 result without operation", out_data, 128'h0);
        end else begin
          logic [127:0] e;
          e = q_exp.pop_front();
          check(out_data === e, "R8 drain", out_data, e);
        end
      end
      @(negedge clk);
    end
    check(q_exp.size() == 0, "R8 every operation delivered", 128'(q_exp.size()), 128'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule